// File: doc/BRIEF.md
# SPI Master with Programmable Lead, Lag and Inter-Transfer Gap

The block moves one word at a time over a four-wire serial link as the clock master. It takes a command holding the transmit word, a 4-bit chip-select pattern, the clock phase and polarity, and three timing settings. The first setting is the SCK half period. The second is the lead, the time from chip-select assertion to the first SCK edge. The third is the gap, the time from chip-select negation to the earliest next assertion. All three count system clock cycles. Any setting outside its legal range is clamped to the nearest legal limit when the command is taken.

Commands enter on a valid/ready channel. The command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` stays low from that cycle until the last cycle of the gap, so a producer holding `cmd_valid` high is back-pressured, and its command fills the link again exactly one gap after the previous chip-select negation. The result side has no back-pressure. `done` is a single-cycle pulse, and `rx_data` keeps the received word from that pulse until the next transfer captures its first bit.

Top module: `spi_delay_master`

## Requirements
- R1: Every SCK level inside a transfer lasts exactly H system cycles, where H is `cmd_half` clamped to 2..255. No SCK level is ever shorter than 2 cycles.
- R2: From the handshake cycle onward `pcs` drives `cmd_cs` unchanged. The first SCK edge comes exactly L cycles after `pcs` asserts, where L is `cmd_lead` clamped to 2..128.
- R3: A transfer has exactly 2×8 SCK edges. `pcs` returns to 0000 exactly H cycles after the last edge.
- R4: After `pcs` negates, the next assertion comes no sooner than D cycles later. It comes exactly D cycles later when a command is already waiting. D is `cmd_gap` clamped to 17..8192.
- R5: Whenever `pcs` is 0000 and a transfer has run, SCK sits at the CPOL level of that transfer. At the assertion of `pcs`, SCK is already at the new CPOL level.
- R6: With CPHA=0, MOSI carries bit 7 from the assertion of `pcs`. MOSI changes only on trailing edges (edges 2, 4, ...), and MISO is sampled on leading edges (edges 1, 3, ...).
- R7: With CPHA=1, MOSI changes on leading edges, the first leading edge presenting bit 7, and MISO is sampled on trailing edges.
- R8: Both directions are most significant bit first. `rx_data` bit 7 is the first MISO bit sampled.
- R9: `done` is high for exactly one cycle, and that cycle is the one in which `pcs` negates. `rx_data` then holds the received word.
- R10: `cmd_ready` is low from the handshake cycle until the last gap cycle. A command offered while `cmd_ready` is low is not taken and does not change the transfer in flight.
- R11: Data, chip-select pattern, CPOL, CPHA and all timing settings are captured at the handshake. Changes on the command inputs afterwards have no effect on the transfer.
- R12: After reset, `sck`=0, `pcs`=0000, `done`=0 and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_data | input | 8 | Word to transmit |
| cmd_cs | input | 4 | Chip-select pattern driven on `pcs` during the transfer |
| cmd_cpol | input | 1 | SCK idle level |
| cmd_cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| cmd_half | input | 8 | SCK half period in cycles (clamped to 2..255) |
| cmd_lead | input | 8 | Chip-select to first edge, in cycles (clamped to 2..128) |
| cmd_gap | input | 14 | Negation to next assertion, in cycles (clamped to 17..8192) |
| done | output | 1 | One-cycle transfer completion pulse |
| rx_data | output | 8 | Received word, valid from `done` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Chip-select outputs, 0000 when idle |

## Verification
A corrupted shared timer shows up at the SCK edge it governs. A wrong lead or half period moves the first or the next edge by whole cycles, which the bench measures against arithmetic expectations within one edge. A wrong edge counter changes the edge count or the position of the `pcs` negation, and this is visible when the transfer ends. A wrong phase selection in the shift path corrupts the word received by the bench's slave model and `rx_data` at `done`. A state machine that restarts or leaves the gap early moves the next chip-select assertion away from exactly D cycles.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_LAG,
    ST_GAP
  } spi_st_t;
endpackage

// File: rtl/spi_dm_clamp.sv
module spi_dm_clamp #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int LO    = 2,
  parameter int HI    = 255
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] val
);
  logic [31:0] wide;
  assign wide = 32'(raw);

  always_comb begin
    if (wide < 32'(LO))      val = OUT_W'(LO);
    else if (wide > 32'(HI)) val = OUT_W'(HI);
    else                     val = OUT_W'(wide);
  end
endmodule

// File: rtl/spi_dm_timer.sv
module spi_dm_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

  AST_TMR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0)); // R4
endmodule

// File: rtl/spi_dm_shift.sv
module spi_dm_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         pre_shift,
  input  logic [W-1:0] load_val,
  input  logic         launch,
  input  logic         capture,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      tx_q <= pre_shift ? {load_val[W-2:0], 1'b0} : load_val;
      mosi <= pre_shift ? load_val[W-1] : 1'b0;
    end else if (launch) begin
      mosi <= tx_q[W-1];
      tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_word <= '0;
    else if (capture) rx_word <= {rx_word[W-2:0], miso};
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && capture)); // R6
endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master
  import spi_dm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CS_W     = 4,
  parameter int HALF_W   = 8,
  parameter int LEAD_W   = 8,
  parameter int GAP_W    = 14,
  parameter int HALF_MIN = 2,
  parameter int HALF_MAX = 255,
  parameter int LEAD_MIN = 2,
  parameter int LEAD_MAX = 128,
  parameter int GAP_MIN  = 17,
  parameter int GAP_MAX  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic              cmd_cpol,
  input  logic              cmd_cpha,
  input  logic [HALF_W-1:0] cmd_half,
  input  logic [LEAD_W-1:0] cmd_lead,
  input  logic [GAP_W-1:0]  cmd_gap,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   pcs
);
  localparam int MAX_HL = (HALF_W > LEAD_W) ? HALF_W : LEAD_W;
  localparam int TMR_W  = (GAP_W > MAX_HL) ? GAP_W : MAX_HL;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);

  spi_st_t            st;
  logic [HALF_W-1:0]  half_c, half_q;
  logic [LEAD_W-1:0]  lead_c;
  logic [GAP_W-1:0]   gap_c, gap_q;
  logic               cpol_q, cpha_q;
  logic [EDGE_W-1:0]  edge_cnt;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic               accept, edge_now, lead_edge, capture, launch;

  spi_dm_clamp #(.IN_W(HALF_W), .OUT_W(HALF_W), .LO(HALF_MIN), .HI(HALF_MAX))
    i_half_clamp (.raw(cmd_half), .val(half_c));
  spi_dm_clamp #(.IN_W(LEAD_W), .OUT_W(LEAD_W), .LO(LEAD_MIN), .HI(LEAD_MAX))
    i_lead_clamp (.raw(cmd_lead), .val(lead_c));
  spi_dm_clamp #(.IN_W(GAP_W), .OUT_W(GAP_W), .LO(GAP_MIN), .HI(GAP_MAX))
    i_gap_clamp (.raw(cmd_gap), .val(gap_c));

  assign cmd_ready = (st == ST_IDLE) || (st == ST_GAP && tmr_zero);
  assign accept    = cmd_valid && cmd_ready;
  assign edge_now  = (st == ST_LEAD || st == ST_SHIFT) && tmr_zero;
  assign lead_edge = ~edge_cnt[0];
  assign capture   = edge_now && (lead_edge ^ cpha_q);
  assign launch    = edge_now && !(lead_edge ^ cpha_q);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(lead_c) - TMR_W'(1);
    end else if (edge_now) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(half_q) - TMR_W'(1);
    end else if (st == ST_LAG && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(gap_q) - TMR_W'(1);
    end
  end

  spi_dm_timer #(.W(TMR_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  spi_dm_shift #(.W(DATA_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .pre_shift (!cmd_cpha),
    .load_val  (cmd_data),
    .launch    (launch),
    .capture   (capture),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      half_q   <= HALF_W'(HALF_MIN);
      gap_q    <= GAP_W'(GAP_MIN);
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      sck      <= 1'b0;
      pcs      <= '0;
      edge_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st       <= ST_LEAD;
        half_q   <= half_c;
        gap_q    <= gap_c;
        cpol_q   <= cmd_cpol;
        cpha_q   <= cmd_cpha;
        sck      <= cmd_cpol;
        pcs      <= cmd_cs;
        edge_cnt <= '0;
      end else begin
        unique case (st)
          ST_LEAD, ST_SHIFT: begin
            if (tmr_zero) begin
              sck      <= ~sck;
              edge_cnt <= edge_cnt + EDGE_W'(1);
              st       <= (edge_cnt == EDGE_W'(EDGES - 1)) ? ST_LAG : ST_SHIFT;
            end
          end
          ST_LAG: begin
            if (tmr_zero) begin
              pcs  <= '0;
              done <= 1'b1;
              st   <= ST_GAP;
            end
          end
          ST_GAP: begin
            if (tmr_zero) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SCK_MIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SHIFT || st == ST_LAG) && !$stable(sck)) |=> $stable(sck)); // R1
  AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT || st == ST_LAG) |-> $stable(pcs)); // R2
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EDGE_W'(EDGES)); // R3
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> (sck == cpol_q)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && st == ST_SHIFT) |=> (st != ST_LEAD)); // R10
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT || st == ST_LAG) |-> ($stable(half_q) && $stable(cpha_q))); // R11
endmodule

// File: tb/test_spi_delay_master.sv
module test_spi_delay_master;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = '0;
  logic [3:0] cmd_cs = '0;
  logic       cmd_cpol = 1'b0;
  logic       cmd_cpha = 1'b0;
  logic [7:0] cmd_half = '0;
  logic [7:0] cmd_lead = '0;
  logic [13:0] cmd_gap = '0;
  logic       done;
  logic [7:0] rx_data;
  logic       sck;
  logic       mosi;
  logic       miso = 1'b0;
  logic [3:0] pcs;

  int checks = 0;
  int errors = 0;

  spi_delay_master i_spi_delay_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_cs(cmd_cs), .cmd_cpol(cmd_cpol), .cmd_cpha(cmd_cpha),
    .cmd_half(cmd_half), .cmd_lead(cmd_lead), .cmd_gap(cmd_gap),
    .done(done), .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .pcs(pcs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side slave model and timing monitor
  int         cyc = 0;
  int         t_on = 0, t_off = 0, t_done = 0, gap_meas = 0, nedges = 0, done_cnt = 0;
  int         edge_t [1:16];
  int         sl_ptr = 0;
  logic [7:0] sl_tx = '0, mosi_rx = '0, rx_at_done = '0;
  logic [3:0] pcs_at_on = '0, prev_pcs = '0;
  logic       prev_sck = 1'b0, sck_at_on = 1'b0, sck_at_off = 1'b0, m_cpha = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (pcs != 4'd0 && prev_pcs == 4'd0) begin
        gap_meas  = cyc - t_off;
        t_on      = cyc;
        pcs_at_on = pcs;
        sck_at_on = sck;
        nedges    = 0;
        mosi_rx   = '0;
        sl_ptr    = 0;
        if (!m_cpha) begin
          miso   = sl_tx[7];
          sl_ptr = 1;
        end
      end else if (pcs != 4'd0 && sck != prev_sck) begin
        nedges = nedges + 1;
        if (nedges <= 16) edge_t[nedges] = cyc;
        if ((nedges % 2 == 1) ^ m_cpha) mosi_rx = {mosi_rx[6:0], mosi};
        else if (sl_ptr < 8) begin
          miso   = sl_tx[7 - sl_ptr];
          sl_ptr = sl_ptr + 1;
        end
      end
      if (pcs == 4'd0 && prev_pcs != 4'd0) begin
        t_off      = cyc;
        sck_at_off = sck;
      end
      if (done) begin
        t_done     = cyc;
        rx_at_done = rx_data;
        done_cnt   = done_cnt + 1;
      end
      prev_pcs = pcs;
      prev_sck = sck;
    end
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<=%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic do_xfer(input bit cpol, input bit cpha, input logic [3:0] cs,
                         input logic [7:0] data, input logic [7:0] stx,
                         input int half, input int lead, input int gap,
                         input bit chk_gap, input int exp_gap);
    int h, l, old, bad;
    h = clampi(half, 2, 255);
    l = clampi(lead, 2, 128);
    sl_tx    = stx;
    m_cpha   = cpha;
    cmd_cpol = cpol;  cmd_cpha = cpha;  cmd_cs = cs;  cmd_data = data;
    cmd_half = 8'(half);  cmd_lead = 8'(lead);  cmd_gap = 14'(gap);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    // R10 R11: a different command stays offered while busy
    cmd_data = ~data;  cmd_cs = ~cs;  cmd_cpol = ~cpol;  cmd_cpha = ~cpha;
    cmd_half = 8'(half + 3);  cmd_lead = 8'(lead + 1);  cmd_gap = 14'(gap + 5);
    old = done_cnt;
    while (done_cnt == old) @(negedge clk);
    chk("R10 ready low while busy", int'(cmd_ready), 0);
    cmd_valid = 1'b0;
    chk("R5 sck level at cs assert", int'(sck_at_on), int'(cpol));
    chk("R5 sck level at cs negate", int'(sck_at_off), int'(cpol));
    chk("R2 cs pattern", int'(pcs_at_on), int'(cs));
    chk("R3 edge count", nedges, 16);
    chk("R2 lead to first edge", edge_t[1] - t_on, l);
    bad = 0;
    for (int k = 2; k <= 16; k++)
      if (edge_t[k] - edge_t[k-1] != h && bad == 0) bad = edge_t[k] - edge_t[k-1];
    chk("R1 half period spacing", (bad == 0) ? h : bad, h);
    chk("R3 lag after last edge", t_off - edge_t[16], h);
    chk("R9 done with cs negation", t_done, t_off);
    if (cpha) chk("R7 R8 mosi word cpha1", int'(mosi_rx), int'(data));
    else      chk("R6 R8 mosi word cpha0", int'(mosi_rx), int'(data));
    chk("R8 rx word at done R11", int'(rx_at_done), int'(stx));
    if (chk_gap) chk("R4 gap between transfers", gap_meas, exp_gap);
  endtask

  function automatic int half_sel(input int i);
    case (i) 0: return 0; 1: return 1; 2: return 3; default: return 6; endcase
  endfunction

  function automatic int lead_sel(input int i);
    case (i) 0: return 0; 1: return 2; 2: return 5; default: return 130; endcase
  endfunction

  initial begin
    int idx, prev_d, g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset sck", int'(sck), 0);
    chk("R12 reset pcs", int'(pcs), 0);
    chk("R12 reset ready", int'(cmd_ready), 1);
    chk("R12 reset done", int'(done), 0);

    idx = 0;
    prev_d = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int hi = 0; hi < 4; hi++)
          for (int li = 0; li < 4; li++) begin
            g = (idx % 2 == 0) ? 0 : 20;
            do_xfer(pol[0], pha[0], 4'((idx % 15) + 1), 8'(8'hA5 ^ (idx * 37)),
                    8'(8'h3C + idx * 11), half_sel(hi), lead_sel(li), g,
                    idx > 0, prev_d);
            prev_d = clampi(g, 17, 8192);
            idx = idx + 1;
          end

    // extremes: widest half period, lead and gap beyond their limits
    do_xfer(1'b0, 1'b1, 4'b1001, 8'h81, 8'h7E, 255, 200, 9000, 1'b1, prev_d);
    do_xfer(1'b1, 1'b0, 4'b0110, 8'h01, 8'h80, 2, 128, 16383, 1'b1, 8192);
    do_xfer(1'b0, 1'b0, 4'b1111, 8'hFF, 8'h00, 2, 2, 17, 1'b1, 8192);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule